// File: doc/BRIEF.md
# Guarded Nonvolatile Data Memory Controller

This block sits behind a small CPU-side register bus and fronts a byte-wide data store that stands in for nonvolatile memory. Software sees four byte registers: an address pointer, a data register, a control/status register and a write-only key register. A read copies the addressed byte into the data register at once, so the next bus read of the data register returns it.

A write to the store is deliberately hard to trigger. Software must first set a write-enable bit with one bus write. It then writes two key bytes in a row to the key register. Only after that may it set the start bit. The store update then takes a parameterised number of clocks. During that time the pointer, data and control registers cannot be changed. When the update lands, the start bit drops by itself and a sticky completion flag, mirrored on an interrupt output, is raised. A reset clears the register file but leaves the store contents alone.

Top module: `nvm_guard_ctrl`

## Requirements
- R1: Synchronous active-high reset sets every register to 0, `irq_done` to 0 and `bus_rdata` to 0, and cancels any write in progress.
- R2: Register select on `bus_reg` is 0 = address, 1 = data, 2 = control, 3 = key. The key register always reads 0x00. `bus_rdata` shows, one clock later, the register selected in the previous cycle.
- R3: A control write with bit 0 (read request) set and bits 7 and 6 clear loads the data register with the addressed byte, so that a bus read in the next cycle returns it. Bit 0 reads back as 1 for exactly one cycle.
- R4: If bit 7 (memory select) or bit 6 (config select) is set in the written control byte, neither a read nor a write starts. The two bits are still stored and read back.
- R5: The data register keeps its value until another read completes or the bus writes it.
- R6: A write starts only when three bus writes come back to back: 0x55 to the key register, then 0xAA to the key register, then a control write with bit 1 (start) set. Any other bus write in between, to any register, cancels the sequence. The sequence is used up by each start attempt.
- R7: The start bit takes effect only if bit 2 (write enable) was already 1 before that bus write. Setting bits 2 and 1 in the same bus write starts nothing.
- R8: Hardware never clears bit 2; it stays 1 after a write completes.
- R9: While a write is in progress, bus writes to the address, data and control registers are ignored, and so is a read request.
- R10: Bit 1 reads 1 for exactly WRITE_CYCLES cycles after the start. Then the byte is committed to the address held in the address register, bit 1 clears, and bit 4 (done) and `irq_done` go to 1.
- R11: The done bit stays 1 until a control write with bit 4 clear, made while no write is in progress. Writing bit 4 as 1 never sets it.
- R12: The stored bytes survive a reset and can be read back afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe for the register chosen by `bus_reg` |
| bus_reg | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Registered read data of the register selected in the previous cycle |
| irq_done | output | 1 | Completion interrupt, equal to the sticky done bit |

## Verification
The assertions assume that reset is held from time zero for at least one clock. They also assume that `bus_reg` and `bus_wdata` carry known values in every cycle. The bench drives all inputs on the falling edge from initialised variables, and it only reads store locations it has already written. A behavioural model of the register file and store runs alongside the design and is compared with `bus_rdata` and `irq_done` on every cycle. Directed sequences then cover each cancelled and accepted unlock, the frozen registers during a write, and the store surviving a reset.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;

  localparam int BUS_W = 8;

  // Register select on the bus
  typedef enum logic [1:0] {
    REG_ADDR = 2'd0,
    REG_DATA = 2'd1,
    REG_CTRL = 2'd2,
    REG_KEY  = 2'd3
  } reg_sel_e;

  // Control register bit positions
  localparam int B_RD   = 0;
  localparam int B_WR   = 1;
  localparam int B_WREN = 2;
  localparam int B_DONE = 4;
  localparam int B_CFG  = 6;
  localparam int B_MEM  = 7;

  // Unlock sequence progress
  typedef enum logic [1:0] {
    K_IDLE  = 2'd0,
    K_FIRST = 2'd1,
    K_ARMED = 2'd2
  } key_state_e;

endpackage

// File: rtl/nvm_unlock_fsm.sv
module nvm_unlock_fsm
  import nvm_guard_pkg::*;
#(
  parameter logic [BUS_W-1:0] KEY_A = 8'h55,
  parameter logic [BUS_W-1:0] KEY_B = 8'hAA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic             key_sel,
  input  logic [BUS_W-1:0] wdata,
  output logic             armed
);

  key_state_e state_q, state_d;

  // Every bus write advances or cancels the sequence
  always_comb begin
    state_d = state_q;
    if (bus_we) begin
      unique case (state_q)
        K_IDLE:  state_d = (key_sel && wdata == KEY_A) ? K_FIRST : K_IDLE;
        K_FIRST: state_d = (key_sel && wdata == KEY_B) ? K_ARMED : K_IDLE;
        default: state_d = K_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= K_IDLE;
    else     state_q <= state_d;
  end

  assign armed = (state_q == K_ARMED);

endmodule

// File: rtl/nvm_write_timer.sv
module nvm_write_timer #(
  parameter int WRITE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic finish
);

  localparam int CW = $clog2(WRITE_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (start)        cnt_q <= CW'(WRITE_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign busy   = (cnt_q != '0);
  assign finish = (cnt_q == CW'(1));

endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);

  localparam int DEPTH = 1 << ADDR_W;

  // No reset on the array or read register so that block RAM can be used
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end

endmodule

// File: rtl/nvm_guard_ctrl.sv
module nvm_guard_ctrl
  import nvm_guard_pkg::*;
#(
  parameter int               ADDR_W       = 4,
  parameter int               WRITE_CYCLES = 16,
  parameter logic [BUS_W-1:0] KEY_A        = 8'h55,
  parameter logic [BUS_W-1:0] KEY_B        = 8'hAA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [1:0]       bus_reg,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq_done
);

  reg_sel_e          sel;
  logic [ADDR_W-1:0] addr_q;
  logic [BUS_W-1:0]  data_q, mem_q, data_cur, ctrl_view;
  logic              use_mem_q;
  logic              msel_q, csel_q, wren_q, rd_q, done_q;
  logic              wr_busy, wr_finish, armed;
  logic              ctrl_wr, sel_ok, wr_start, rd_start;

  assign sel     = reg_sel_e'(bus_reg);
  assign ctrl_wr = bus_we && (sel == REG_CTRL);
  assign sel_ok  = !bus_wdata[B_MEM] && !bus_wdata[B_CFG];

  // Start needs: armed key sequence, enable from an earlier write, idle timer
  assign wr_start = ctrl_wr && bus_wdata[B_WR] && sel_ok && wren_q && armed && !wr_busy;
  assign rd_start = ctrl_wr && bus_wdata[B_RD] && sel_ok && !wr_busy && !wr_start;

  nvm_unlock_fsm #(
    .KEY_A(KEY_A),
    .KEY_B(KEY_B)
  ) u_unlock (
    .clk    (clk),
    .rst    (rst),
    .bus_we (bus_we),
    .key_sel(sel == REG_KEY),
    .wdata  (bus_wdata),
    .armed  (armed)
  );

  nvm_write_timer #(
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (wr_start),
    .busy  (wr_busy),
    .finish(wr_finish)
  );

  nvm_store #(
    .ADDR_W(ADDR_W),
    .DATA_W(BUS_W)
  ) u_store (
    .clk  (clk),
    .we   (wr_finish && !rst),
    .waddr(addr_q),
    .wdata(data_cur),
    .re   (rd_start),
    .raddr(addr_q),
    .q    (mem_q)
  );

  // Data register view: last fetched byte or last bus-written byte
  assign data_cur = use_mem_q ? mem_q : data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      data_q    <= '0;
      use_mem_q <= 1'b0;
      msel_q    <= 1'b0;
      csel_q    <= 1'b0;
      wren_q    <= 1'b0;
      rd_q      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      rd_q <= rd_start;
      if (rd_start) use_mem_q <= 1'b1;
      if (wr_finish) done_q <= 1'b1;
      if (!wr_busy && bus_we) begin
        unique case (sel)
          REG_ADDR: addr_q <= bus_wdata[ADDR_W-1:0];
          REG_DATA: begin
            data_q    <= bus_wdata;
            use_mem_q <= 1'b0;
          end
          REG_CTRL: begin
            msel_q <= bus_wdata[B_MEM];
            csel_q <= bus_wdata[B_CFG];
            wren_q <= bus_wdata[B_WREN];
            done_q <= done_q && bus_wdata[B_DONE];
          end
          default: ;
        endcase
      end
    end
  end

  assign ctrl_view = {msel_q, csel_q, 1'b0, done_q, 1'b0, wren_q, wr_busy, rd_q};

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (sel)
        REG_ADDR: bus_rdata <= BUS_W'(addr_q);
        REG_DATA: bus_rdata <= data_cur;
        REG_CTRL: bus_rdata <= ctrl_view;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign irq_done = done_q;

endmodule

// File: rtl/nvm_guard_checker.sv
module nvm_guard_checker #(
  parameter int ADDR_W       = 4,
  parameter int WRITE_CYCLES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [1:0]        bus_reg,
  input logic [7:0]        bus_wdata,
  input logic              irq_done,
  input logic              wr_busy,
  input logic              rd_q,
  input logic              wren_q,
  input logic              done_q,
  input logic [ADDR_W-1:0] addr_q
);

  localparam int LW = $clog2(WRITE_CYCLES + 2) + 1;

  logic [LW-1:0] run_len;
  logic          ctrl_wr;

  assign ctrl_wr = bus_we && (bus_reg == 2'd2);

  // Length of the current busy stretch, checked when it ends
  always_ff @(posedge clk) begin
    if (rst)          run_len <= '0;
    else if (wr_busy) run_len <= run_len + LW'(1);
    else              run_len <= '0;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!irq_done && !wr_busy && !rd_q && !wren_q));

  a_r3_rd_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rd_q && !(ctrl_wr && bus_wdata[0]) |=> !rd_q);

  a_r7_no_same_write_start: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && bus_wdata[1] && !wren_q && !wr_busy |=> !wr_busy);

  a_r8_wren_held: assert property (@(posedge clk) disable iff (rst)
    wren_q && !ctrl_wr |=> wren_q);

  a_r9_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    wr_busy |=> $stable(addr_q));

  a_r9_no_read_while_busy: assert property (@(posedge clk) disable iff (rst)
    !(wr_busy && rd_q));

  a_r10_write_length: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_busy) && !$past(rst) |-> run_len == LW'(WRITE_CYCLES));

  a_r10_done_on_end: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_busy) && !$past(rst) |-> (done_q && irq_done));

  a_r11_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done_q && !(ctrl_wr && !wr_busy && !bus_wdata[4]) |=> done_q);

endmodule

bind nvm_guard_ctrl nvm_guard_checker #(
  .ADDR_W      (ADDR_W),
  .WRITE_CYCLES(WRITE_CYCLES)
) u_nvm_guard_checker (
  .clk      (clk),
  .rst      (rst),
  .bus_we   (bus_we),
  .bus_reg  (bus_reg),
  .bus_wdata(bus_wdata),
  .irq_done (irq_done),
  .wr_busy  (wr_busy),
  .rd_q     (rd_q),
  .wren_q   (wren_q),
  .done_q   (done_q),
  .addr_q   (addr_q)
);

// File: tb/test_nvm_guard_ctrl.sv
module test_nvm_guard_ctrl;

  localparam int ADDR_W = 4;
  localparam int WC     = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [1:0] bus_reg = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_done;

  always #4 clk = ~clk;

  nvm_guard_ctrl #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WC)) i_nvm_guard_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_reg  (bus_reg),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_done (irq_done)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // Behavioural reference state
  logic [7:0] m_mem [16];
  int         m_addr, m_rem, m_key;
  logic [7:0] m_data, m_rdata;
  bit         m_msel, m_csel, m_wren, m_rd, m_done;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [7:0] cv;
    bit busy, cw, kw, wgo, rgo, ok;
    if (rst) begin
      m_addr = 0; m_data = 0; m_rdata = 0; m_rem = 0; m_key = 0;
      m_msel = 0; m_csel = 0; m_wren = 0; m_rd = 0; m_done = 0;
      return;
    end
    busy = (m_rem > 0);
    cv = {m_msel, m_csel, 1'b0, m_done, 1'b0, m_wren, busy, m_rd};
    case (bus_reg)
      2'd0: m_rdata = 8'(m_addr);
      2'd1: m_rdata = m_data;
      2'd2: m_rdata = cv;
      default: m_rdata = 8'h00;
    endcase
    cw  = bus_we && bus_reg == 2'd2;
    kw  = bus_we && bus_reg == 2'd3;
    ok  = bus_wdata[7:6] == 2'b00;
    wgo = cw && bus_wdata[1] && ok && m_wren && m_key == 2 && !busy;
    rgo = cw && bus_wdata[0] && ok && !busy && !wgo;
    if (m_rem == 1) begin
      m_mem[m_addr] = m_data;
      m_done = 1;
    end
    m_rem = wgo ? WC : (m_rem > 0 ? m_rem - 1 : 0);
    m_rd = rgo;
    if (rgo) m_data = m_mem[m_addr];
    if (!busy && bus_we && bus_reg == 2'd0) m_addr = int'(bus_wdata[ADDR_W-1:0]);
    if (!busy && bus_we && bus_reg == 2'd1) m_data = bus_wdata;
    if (!busy && cw) begin
      m_msel = bus_wdata[7];
      m_csel = bus_wdata[6];
      m_wren = bus_wdata[2];
      m_done = m_done && bus_wdata[4];
    end
    if (bus_we) begin
      if (m_key == 0 && kw && bus_wdata == 8'h55)      m_key = 1;
      else if (m_key == 1 && kw && bus_wdata == 8'hAA) m_key = 2;
      else                                              m_key = 0;
    end
  endtask

  // One bus cycle, driven on the falling edge and compared after the rising edge
  task automatic cyc(input bit we, input logic [1:0] rg, input logic [7:0] wd);
    bus_we = we; bus_reg = rg; bus_wdata = wd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R2 model rdata", bus_rdata, m_rdata);
    check("R10 model irq", {7'd0, irq_done}, {7'd0, m_done});
  endtask

  task automatic wr(input logic [1:0] rg, input logic [7:0] v);
    cyc(1'b1, rg, v);
  endtask

  task automatic rd(input logic [1:0] rg, output logic [7:0] v);
    cyc(1'b0, rg, 8'h00);
    v = bus_rdata;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic wait_idle(output int busy_reads, output logic [7:0] last);
    busy_reads = 0;
    last = 8'h00;
    for (int i = 0; i < 40; i++) begin
      rd(2'd2, last);
      if (!last[1]) break;
      busy_reads++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    logic [7:0] v;
    int cnt;
    @(negedge clk);
    rst = 1'b1;
    cyc(1'b0, 2'd0, 8'h00);
    cyc(1'b0, 2'd0, 8'h00);
    rst = 1'b0;

    // R1 reset values
    rd(2'd2, v); check("R1 control", v, 8'h00);
    rd(2'd0, v); check("R1 address", v, 8'h00);
    rd(2'd1, v); check("R1 data", v, 8'h00);
    check("R1 irq", {7'd0, irq_done}, 8'h00);

    // R2 register map
    wr(2'd0, 8'h03); rd(2'd0, v); check("R2 address readback", v, 8'h03);
    wr(2'd3, 8'h77); rd(2'd3, v); check("R2 key reads zero", v, 8'h00);
    wr(2'd1, 8'h5A); rd(2'd1, v); check("R2 data readback", v, 8'h5A);

    // R10 first guarded write: 0x5A to address 3
    wr(2'd2, 8'h04);
    wr(2'd3, 8'h55);
    wr(2'd3, 8'hAA);
    wr(2'd2, 8'h06);
    wait_idle(cnt, v);
    check("R10 busy length", 8'(cnt), 8'(WC));
    check("R10 done set, R8 enable kept", v, 8'h14);
    check("R10 irq high", {7'd0, irq_done}, 8'h01);

    // R3 read back through the data register
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h15);
    rd(2'd1, v); check("R3 read data next cycle", v, 8'h5A);
    wr(2'd2, 8'h15);
    rd(2'd2, v); check("R3 read bit set one cycle", v, 8'h15);
    rd(2'd2, v); check("R3 read bit self-clears", v, 8'h14);

    // R11 done is sticky until cleared
    check("R11 done kept by writing 1", v, 8'h14);
    wr(2'd2, 8'h04);
    rd(2'd2, v); check("R11 done cleared", v, 8'h04);
    check("R11 irq cleared", {7'd0, irq_done}, 8'h00);

    // R5 data holds
    wr(2'd1, 8'h3C);
    wr(2'd2, 8'h04);
    wr(2'd0, 8'h03);
    rd(2'd1, v); check("R5 data held", v, 8'h3C);

    // R7 enable and start in one write
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h55);
    wr(2'd3, 8'hAA);
    wr(2'd2, 8'h06);
    rd(2'd2, v); check("R7 no start in same write", v, 8'h04);

    // R6 broken unlock sequences
    wr(2'd3, 8'h55); wr(2'd0, 8'h03); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
    rd(2'd2, v); check("R6 other register between keys", v, 8'h04);
    wr(2'd3, 8'h55); wr(2'd3, 8'h33); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
    rd(2'd2, v); check("R6 wrong second key", v, 8'h04);
    wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h04); wr(2'd2, 8'h06);
    rd(2'd2, v); check("R6 control write without start", v, 8'h04);

    // R4 select bits block access
    wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h86);
    rd(2'd2, v); check("R4 memory select blocks write", v, 8'h84);
    wr(2'd2, 8'h41);
    rd(2'd2, v); check("R4 config select blocks read", v, 8'h40);
    rd(2'd1, v); check("R4 data unchanged", v, 8'h3C);
    wr(2'd2, 8'h04);

    // R9 second write: 0xC3 to address 5, bus writes ignored while busy
    wr(2'd0, 8'h05);
    wr(2'd1, 8'hC3);
    wr(2'd3, 8'h55);
    wr(2'd3, 8'hAA);
    wr(2'd2, 8'h06);
    wr(2'd0, 8'h09);
    wr(2'd1, 8'h11);
    wr(2'd2, 8'h01);
    wr(2'd2, 8'h00);
    rd(2'd0, v); check("R9 address frozen", v, 8'h05);
    rd(2'd1, v); check("R9 data frozen", v, 8'hC3);
    rd(2'd2, v); check("R9 control frozen, no read", v, 8'h06);
    wait_idle(cnt, v);
    check("R10 second write done", v, 8'h14);

    // R6 sequence consumed: start again without unlock
    wr(2'd2, 8'h16);
    rd(2'd2, v); check("R6 unlock used up", v, 8'h14);
    wr(2'd2, 8'h04);

    // R12 store survives reset
    rst = 1'b1;
    cyc(1'b0, 2'd0, 8'h00);
    rst = 1'b0;
    rd(2'd2, v); check("R1 control after reset", v, 8'h00);
    wr(2'd0, 8'h03); wr(2'd2, 8'h01);
    rd(2'd1, v); check("R12 address 3 kept", v, 8'h5A);
    wr(2'd0, 8'h05); wr(2'd2, 8'h01);
    rd(2'd1, v); check("R12 address 5 kept", v, 8'hC3);

    finished = 1;
    report();
  end

endmodule